// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides its input clock by a programmable ratio K = 64·N + A. It models a divide-by-64/65 prescaler as an internal cycle counter. A main counter (N) and a swallow counter (A) steer that prescaler. The block emits one single-cycle pulse per K input cycles, which is the divided signal fed to a phase comparator in a synthesizer loop.

Both counters count down once per prescaler period. While the swallow counter is non-zero, the prescaler spans 65 input cycles and the modulus-control output is high. Once the swallow counter reaches zero it stays there, and the prescaler spans 64 cycles. When the main counter finishes its last prescaler period, the output pulse fires and both counters reload.

New ratios are offered with a load strobe. A legal pair is held pending and takes effect only at the next period boundary. An illegal pair, where A is not smaller than N, is refused and reported on an error output. With the reset ratio N = 27, A = 22 (K = 1750), a 17.5 MHz input produces a 10 kHz output.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its reset state: `pulse_out` = 0, `cfg_err` = 0, ratio N = 27 and A = 22, so `mod_ctl` = 1. After release, the first `pulse_out` appears in the 1750th cycle, counting the first sampled state after release as cycle 1.
- R2: In steady state, `pulse_out` is asserted exactly once every K = 64·N + A input cycles. For example, N = 27 and A = 22 gives K = 1750, which turns 17.5 MHz into 10 kHz.
- R3: `pulse_out` is never high for two consecutive cycles.
- R4: Within each output period, `mod_ctl` (1 = prescaler dividing by 65) is high for exactly 65·A cycles. Those cycles form the start of the period.
- R5: Once `mod_ctl` is low, it stays low until the cycle after the period's `pulse_out`. The swallow counter holds at zero until the main counter finishes.
- R6: A legal load (`a_in` < `n_in`, both unsigned) changes nothing in the period under way. The new ratio governs the periods that start after the next `pulse_out`.
- R7: A load with `a_in` ≥ `n_in` raises `cfg_err` for exactly the one cycle after the strobe. The ratio in use and any pending ratio stay unchanged.
- R8: A legal load leaves `cfg_err` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Strobe offering `n_in`/`a_in` as the next ratio |
| n_in | input | CW (8) | Main counter value N |
| a_in | input | CW (8) | Swallow counter value A, must be below N |
| pulse_out | output | 1 | Divided output, one cycle wide per K cycles |
| mod_ctl | output | 1 | Prescaler modulus: 1 = divide by 65, 0 = divide by 64 |
| cfg_err | output | 1 | One-cycle flag for a refused load |

## Verification
The bench builds the block with its default parameters: a 6-bit prescaler exponent (64/65), 8-bit counters and the 27/22 reset ratio. This keeps the full 1750-cycle period within reach, along with the smallest legal ratios: N = 1 with A = 0 (64 cycles) and N = 2 with A = 1 (129 cycles). Short ratios let every swallow phase and every reload boundary be measured end to end. The long default ratio gives room to place a load deep inside a period and show that the period finishes unchanged. Refused loads with A equal to N, and with both zero, are shown to leave the measured period untouched.

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int PB     = 6,
  parameter int CW     = 8,
  parameter int N_INIT = 27,
  parameter int A_INIT = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] n_in,
  input  logic [CW-1:0] a_in,
  output logic          pulse_out,
  output logic          mod_ctl,
  output logic          cfg_err
);
  localparam int P = 1 << PB;

  logic [PB:0]   pre_cnt;
  logic [CW-1:0] n_cnt, a_cnt;
  logic [CW-1:0] n_prog, a_prog;
  logic [CW-1:0] n_pend, a_pend;
  logic          pend_v;
  logic          err_q;

  wire           cfg_ok   = a_in < n_in;
  wire [PB:0]    pre_last = mod_ctl ? (PB+1)'(P) : (PB+1)'(P - 1);
  wire           tick     = pre_cnt == pre_last;
  wire           wrap     = tick && (n_cnt == CW'(1));
  wire [CW-1:0]  n_next   = pend_v ? n_pend : n_prog;
  wire [CW-1:0]  a_next   = pend_v ? a_pend : a_prog;

  assign mod_ctl   = a_cnt != '0;
  assign pulse_out = wrap;
  assign cfg_err   = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      n_cnt   <= CW'(N_INIT);
      a_cnt   <= CW'(A_INIT);
      n_prog  <= CW'(N_INIT);
      a_prog  <= CW'(A_INIT);
      n_pend  <= '0;
      a_pend  <= '0;
      pend_v  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q   <= load && !cfg_ok;
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) begin
        if (wrap) begin
          n_cnt  <= n_next;
          a_cnt  <= a_next;
          n_prog <= n_next;
          a_prog <= a_next;
        end else begin
          n_cnt <= n_cnt - 1'b1;
          if (mod_ctl) a_cnt <= a_cnt - 1'b1;
        end
      end
      if (load && cfg_ok) begin
        n_pend <= n_in;
        a_pend <= a_in;
        pend_v <= 1'b1;
      end else if (wrap) begin
        pend_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic [CW-1:0] n_in,
  input logic [CW-1:0] a_in,
  input logic          pulse_out,
  input logic          mod_ctl,
  input logic          cfg_err
);
  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_out |=> !pulse_out);

  // R4
  swallow_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_ctl) |-> $past(pulse_out));

  // R5
  swallow_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (!mod_ctl && !pulse_out) |=> !mod_ctl);

  // R7
  bad_load_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !(a_in < n_in)) |=> cfg_err);

  // R8
  good_load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (load && (a_in < n_in)) |=> !cfg_err);

  // R7
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !$past(load)) |-> 1'b0);
endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .load(load), .n_in(n_in), .a_in(a_in),
  .pulse_out(pulse_out), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
);

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [7:0] n_in = '0;
  logic [7:0] a_in = '0;
  logic       pulse_out, mod_ctl, cfg_err;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pulse_swallow_div dut (
    .clk(clk), .rst(rst), .load(load), .n_in(n_in), .a_in(a_in),
    .pulse_out(pulse_out), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
  );

  localparam int NV = 5;
  localparam int VN [NV] = '{27, 3, 5, 1, 2};
  localparam int VA [NV] = '{22, 0, 4, 0, 1};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int len, output int modc);
    len = 0;
    modc = 0;
    do begin
      @(negedge clk);
      len++;
      if (mod_ctl) modc++;
    end while (!pulse_out && len < 5000);
  endtask

  task automatic wait_pulse();
    int c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!pulse_out && c < 5000);
  endtask

  task automatic strobe(input int n, input int a);
    load = 1'b1;
    n_in = 8'(n);
    a_in = 8'(a);
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    int len, modc, c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state visible at release
    check("R1 pulse_out", int'(pulse_out), 0);
    check("R1 cfg_err", int'(cfg_err), 0);
    check("R1 mod_ctl", int'(mod_ctl), 1);

    // R1/R6: first period runs 1750 states; a legal load at step 100 must not shorten it
    c = 0;
    do begin
      @(negedge clk);
      c++;
      if (c == 100) begin
        load = 1'b1; n_in = 8'd3; a_in = 8'd0;
      end else if (c == 101) begin
        load = 1'b0;
      end
    end while (!pulse_out && c < 5000);
    check("R1/R6 first period", c, 1749);
    measure(len, modc);
    check("R6 new ratio after boundary", len, 192);

    // R2/R4 vector walk
    for (int i = 0; i < NV; i++) begin
      strobe(VN[i], VA[i]);
      wait_pulse();
      measure(len, modc);
      check("R2 period", len, 64 * VN[i] + VA[i]);
      check("R4 swallow cycles", modc, 65 * VA[i]);
    end

    // R7 refused load A == N; current ratio is N=2, A=1
    strobe(4, 4);
    check("R7 cfg_err raised", int'(cfg_err), 1);
    @(negedge clk);
    check("R7 cfg_err one cycle", int'(cfg_err), 0);
    wait_pulse();
    measure(len, modc);
    check("R7 ratio kept", len, 129);

    // R7 refused load of zeros
    strobe(0, 0);
    check("R7 zero load flagged", int'(cfg_err), 1);
    wait_pulse();
    measure(len, modc);
    check("R7 ratio kept after zero load", len, 129);

    // R8 legal load is quiet and applies
    strobe(5, 3);
    check("R8 cfg_err low", int'(cfg_err), 0);
    wait_pulse();
    measure(len, modc);
    check("R8 ratio applied", len, 323);

    // R1 mid-run reset restores the default ratio
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 mod_ctl after reset", int'(mod_ctl), 1);
    measure(len, modc);
    check("R1 first period after reset", len, 1749);

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule